// File: doc/BRIEF.md
# Power-Management Configuration and APM Command Decoder

This block is the register front end of a power-management function on a PCI bus. It holds the few configuration bytes the function actually implements. From them it decodes two relocatable I/O windows. The first is a 64-byte power-management window. The second is a system-management bus window. Each window is driven out as a 16-bit aligned base plus an enable bit. Configuration accesses are dword-addressed and carry per-byte enables. Reads are combinational. Offsets that the block does not implement read as zero.

The block also watches the APM control port. Two command values switch the SCI enable flag on and off. Any other value is a request for a system-management interrupt. That request becomes a one-cycle pulse, but only if software has enabled SMI generation in the configuration space. A parameter selects whether the platform supports system-management mode. Without it, reset marks SMI handling as already initialised.

Top module: `pmcfg_apm`

## Requirements
- R1: After reset, config dwords read as follows:
  - 0x04 reads 0x02800000.
  - 0x3C reads 0x00000100.
  - 0x40 reads 0x00000001.
  - 0x58 reads 0 (with SMM_SUPPORT=1).
  - 0x80 reads 0.
  - 0x90 reads {16'h0, SMB_BASE_INIT | 1}.
  - 0xD0 reads 0x00090000.
  - The outputs are pm_en=0, sci_en=0, smi_pulse=0, smb_en=1 and smb_base=SMB_BASE_INIT & 0xFFC0.
- R2: pm_base equals bits 15:0 of config dword 0x40 masked with 0xFFC0. A write that updates it takes effect on the same clock edge that accepts the write. Only the byte lanes whose byte enable is set (cfg_be[i] covers bits 8i+7:8i) are written.
- R3: pm_en equals bit 0 of config byte 0x80 (dword 0x80, lane 0).
- R4: smb_base equals bits 15:0 of config dword 0x90 masked with 0xFFC0. smb_en equals bit 0 of config byte 0xD2 (dword 0xD0, lane 2).
- R5: The window outputs change only on a config write whose enabled lanes touch bytes 0x40–0x43 or byte 0x80 (PM window), or bytes 0x90–0x93 or byte 0xD2 (SMBus window). A write with no enabled lane on those bytes leaves them unchanged.
- R6: Bit 0 of bytes 0x40 and 0x90 always reads 1. Writes to dwords 0x04 and 0x3C, and to unimplemented offsets, have no effect. Unimplemented offsets read zero.
- R7: An APM write of 0xF1 sets sci_en from the next cycle, and an APM write of 0xF0 clears it. Neither value produces an smi_pulse.
- R8: An APM write of any other value makes smi_pulse high for exactly the one cycle after the write. This happens only if bit 1 of config byte 0x5B (bit 25 of dword 0x58) is set. Otherwise smi_pulse stays low.
- R9: When a config write and an APM write fall in the same cycle, the SMI decision uses the value that byte 0x5B held before that config write.
- R10: With SMM_SUPPORT=0, byte 0x5B resets to 0x02, so dword 0x58 reads 0x02000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_dw | input | 6 | Config dword index (byte offset bits 7:2) |
| cfg_be | input | 4 | Per-lane byte enables for writes |
| cfg_wdata | input | 32 | Config write data, little-endian lanes |
| cfg_rdata | output | 32 | Config read data for cfg_dw |
| apm_wr | input | 1 | APM control port write strobe |
| apm_data | input | 8 | APM control value |
| pm_base | output | 16 | Power-management window base |
| pm_en | output | 1 | Power-management window enable |
| smb_base | output | 16 | SMBus window base |
| smb_en | output | 1 | SMBus window enable |
| sci_en | output | 1 | SCI enable flag |
| smi_pulse | output | 1 | One-cycle SMI request |

## Verification
A config write that changes the SMI-enable bit in byte 0x5B can arrive in the same cycle as an APM control write that carries an SMI request. The bench drives both strobes on one edge in each direction: first clearing the bit while requesting, then setting it while requesting. It expects the pulse to follow the old bit value each time. Follow-up requests made alone then show that the new bit value took hold on the next cycle.

// File: rtl/pmcfg_apm.sv
module pmcfg_apm #(
  parameter bit          SMM_SUPPORT   = 1'b1,
  parameter logic [15:0] SMB_BASE_INIT = 16'h0B00,
  parameter int          ALIGN_BITS    = 6,
  parameter logic [7:0]  CMD_SCI_ON    = 8'hF1,
  parameter logic [7:0]  CMD_SCI_OFF   = 8'hF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [5:0]  cfg_dw,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        apm_wr,
  input  logic [7:0]  apm_data,
  output logic [15:0] pm_base,
  output logic        pm_en,
  output logic [15:0] smb_base,
  output logic        smb_en,
  output logic        sci_en,
  output logic        smi_pulse
);
  localparam logic [15:0] BASE_MASK = 16'hFFFF << ALIGN_BITS;
  localparam logic [5:0]  DW_ID   = 6'h01;
  localparam logic [5:0]  DW_INTR = 6'h0F;
  localparam logic [5:0]  DW_PMB  = 6'h10;
  localparam logic [5:0]  DW_SMI  = 6'h16;
  localparam logic [5:0]  DW_PMC  = 6'h20;
  localparam logic [5:0]  DW_SMB  = 6'h24;
  localparam logic [5:0]  DW_SMC  = 6'h34;
  localparam logic [31:0] SMI_RST = SMM_SUPPORT ? 32'h0 : 32'h0200_0000;
  localparam int          SMI_BIT = 25;

  logic [31:0] pmb_q, smi_q, smb_q;
  logic [7:0]  pmc_q, smc_q;

  function automatic logic [31:0] lane_merge(input logic [31:0] old,
                                             input logic [31:0] wd,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[i*8 +: 8] = be[i] ? wd[i*8 +: 8] : old[i*8 +: 8];
    return r;
  endfunction

  wire wr_pmb = cfg_wr && cfg_dw == DW_PMB && |cfg_be;
  wire wr_smi = cfg_wr && cfg_dw == DW_SMI && |cfg_be;
  wire wr_pmc = cfg_wr && cfg_dw == DW_PMC && cfg_be[0];
  wire wr_smb = cfg_wr && cfg_dw == DW_SMB && |cfg_be;
  wire wr_smc = cfg_wr && cfg_dw == DW_SMC && cfg_be[2];

  wire [31:0] pmb_nx = wr_pmb ? (lane_merge(pmb_q, cfg_wdata, cfg_be) | 32'h1) : pmb_q;
  wire [31:0] smb_nx = wr_smb ? (lane_merge(smb_q, cfg_wdata, cfg_be) | 32'h1) : smb_q;
  wire [7:0]  pmc_nx = wr_pmc ? cfg_wdata[7:0]   : pmc_q;
  wire [7:0]  smc_nx = wr_smc ? cfg_wdata[23:16] : smc_q;

  wire cmd_on  = apm_data == CMD_SCI_ON;
  wire cmd_off = apm_data == CMD_SCI_OFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmb_q     <= 32'h0000_0001;
      smi_q     <= SMI_RST;
      pmc_q     <= 8'h00;
      smb_q     <= {16'h0, SMB_BASE_INIT | 16'h0001};
      smc_q     <= 8'h09;
      pm_base   <= 16'h0001 & BASE_MASK;
      pm_en     <= 1'b0;
      smb_base  <= SMB_BASE_INIT & BASE_MASK;
      smb_en    <= 1'b1;
      sci_en    <= 1'b0;
      smi_pulse <= 1'b0;
    end else begin
      pmb_q <= pmb_nx;
      smb_q <= smb_nx;
      pmc_q <= pmc_nx;
      smc_q <= smc_nx;
      if (wr_smi) smi_q <= lane_merge(smi_q, cfg_wdata, cfg_be);
      if (wr_pmb || wr_pmc) begin
        pm_base <= pmb_nx[15:0] & BASE_MASK;
        pm_en   <= pmc_nx[0];
      end
      if (wr_smb || wr_smc) begin
        smb_base <= smb_nx[15:0] & BASE_MASK;
        smb_en   <= smc_nx[0];
      end
      if (apm_wr && cmd_on)  sci_en <= 1'b1;
      if (apm_wr && cmd_off) sci_en <= 1'b0;
      smi_pulse <= apm_wr && !cmd_on && !cmd_off && smi_q[SMI_BIT];
    end
  end

  always_comb begin
    case (cfg_dw)
      DW_ID:   cfg_rdata = 32'h0280_0000;
      DW_INTR: cfg_rdata = 32'h0000_0100;
      DW_PMB:  cfg_rdata = pmb_q;
      DW_SMI:  cfg_rdata = smi_q;
      DW_PMC:  cfg_rdata = {24'h0, pmc_q};
      DW_SMB:  cfg_rdata = smb_q;
      DW_SMC:  cfg_rdata = {8'h0, smc_q, 16'h0};
      default: cfg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/pmcfg_apm_chk.sv
module pmcfg_apm_chk #(
  parameter logic [7:0] ON_CMD  = 8'hF1,
  parameter logic [7:0] OFF_CMD = 8'hF0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [5:0]  cfg_dw,
  input logic [3:0]  cfg_be,
  input logic        apm_wr,
  input logic [7:0]  apm_data,
  input logic [15:0] pm_base,
  input logic        pm_en,
  input logic [15:0] smb_base,
  input logic        smb_en,
  input logic        sci_en,
  input logic        smi_pulse
);
  logic pm_touch, smb_touch;
  assign pm_touch  = cfg_wr && ((cfg_dw == 6'h10 && cfg_be != 4'h0) || (cfg_dw == 6'h20 && cfg_be[0]));
  assign smb_touch = cfg_wr && ((cfg_dw == 6'h24 && cfg_be != 4'h0) || (cfg_dw == 6'h34 && cfg_be[2]));

  assert_sci_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && apm_data == ON_CMD) |=> sci_en);
  assert_sci_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && apm_data == OFF_CMD) |=> !sci_en);
  assert_sci_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !apm_wr |=> $stable(sci_en));
  assert_smi_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |-> ($past(apm_wr) && $past(apm_data) != ON_CMD && $past(apm_data) != OFF_CMD));
  assert_pm_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_touch |=> ($stable(pm_base) && $stable(pm_en)));
  assert_smb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !smb_touch |=> ($stable(smb_base) && $stable(smb_en)));
endmodule

bind pmcfg_apm pmcfg_apm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
  .apm_wr(apm_wr), .apm_data(apm_data), .pm_base(pm_base), .pm_en(pm_en),
  .smb_base(smb_base), .smb_en(smb_en), .sci_en(sci_en), .smi_pulse(smi_pulse)
);

// File: tb/pmcfg_apm_bench.sv
module pmcfg_apm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_dw = 6'h0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic        apm_wr = 1'b0;
  logic [7:0]  apm_data = 8'h0;
  logic [31:0] cfg_rdata, n_rdata;
  logic [15:0] pm_base, smb_base, n_pmb, n_smbb;
  logic        pm_en, smb_en, sci_en, smi_pulse, n_pme, n_smbe, n_sci, n_smi;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pmcfg_apm u_pmcfg_apm (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .apm_wr(apm_wr), .apm_data(apm_data),
    .pm_base(pm_base), .pm_en(pm_en), .smb_base(smb_base), .smb_en(smb_en),
    .sci_en(sci_en), .smi_pulse(smi_pulse));

  pmcfg_apm #(.SMM_SUPPORT(1'b0)) u_nosmm (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(n_rdata), .apm_wr(apm_wr), .apm_data(apm_data),
    .pm_base(n_pmb), .pm_en(n_pme), .smb_base(n_smbb), .smb_en(n_smbe),
    .sci_en(n_sci), .smi_pulse(n_smi));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic w, input logic [7:0] addr, input logic [3:0] be,
                       input logic [31:0] d, input logic a, input logic [7:0] ad);
    cfg_wr = w; cfg_dw = addr[7:2]; cfg_be = be; cfg_wdata = d;
    apm_wr = a; apm_data = ad;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0; apm_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic rd(input logic [7:0] addr, output logic [31:0] v);
    cfg_dw = addr[7:2];
    #1 v = cfg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h04, v); chk("R1 id", v, 32'h0280_0000);
    rd(8'h3C, v); chk("R1 intr", v, 32'h0000_0100);
    rd(8'h40, v); chk("R1 pmb", v, 32'h0000_0001);
    rd(8'h58, v); chk("R1 smi", v, 32'h0);
    rd(8'h80, v); chk("R1 pmc", v, 32'h0);
    rd(8'h90, v); chk("R1 smb", v, 32'h0000_0B01);
    rd(8'hD0, v); chk("R1 smc", v, 32'h0009_0000);
    rd(8'h00, v); chk("R6 unimpl read", v, 32'h0);
    chk("R1 outs", {pm_en, smb_en, sci_en, smi_pulse}, 4'b0100);
    chk("R1 smb_base", smb_base, 16'h0B00);
    rd(8'h58, v); v = n_rdata; chk("R10 nosmm 5B", v, 32'h0200_0000);
  endtask

  task automatic t_pm_window;
    logic [31:0] v;
    cycle(1, 8'h40, 4'hF, 32'h0000_1234, 0, 8'h0);
    chk("R2 pm_base", pm_base, 16'h1200);
    chk("R3 pm_en still off", pm_en, 1'b0);
    rd(8'h40, v); chk("R6 bit0 forced", v, 32'h0000_1235);
    cycle(1, 8'h80, 4'h1, 32'h0000_0001, 0, 8'h0);
    chk("R3 pm_en on", pm_en, 1'b1);
    cycle(1, 8'h40, 4'h2, 32'h0000_AB00, 0, 8'h0);
    chk("R2 lane write base", pm_base, 16'hAB00);
    rd(8'h40, v); chk("R2 lane readback", v, 32'h0000_AB35);
  endtask

  task automatic t_smb_window;
    logic [31:0] v;
    cycle(1, 8'h90, 4'h3, 32'h0000_C0FF, 0, 8'h0);
    chk("R4 smb_base", smb_base, 16'hC0C0);
    rd(8'h90, v); chk("R4 smb readback", v, 32'h0000_C0FF);
    cycle(1, 8'hD0, 4'h4, 32'h0000_0000, 0, 8'h0);
    chk("R4 smb_en off", smb_en, 1'b0);
    rd(8'hD0, v); chk("R4 smc readback", v, 32'h0);
  endtask

  task automatic t_ignore;
    logic [31:0] v;
    cycle(1, 8'h40, 4'h0, 32'hFFFF_FFFF, 0, 8'h0);
    chk("R5 no-lane write", pm_base, 16'hAB00);
    cycle(1, 8'h80, 4'hE, 32'h0000_0000, 0, 8'h0);
    chk("R5 other lanes of 0x80", pm_en, 1'b1);
    rd(8'h80, v); chk("R5 0x80 readback", v, 32'h1);
    cycle(1, 8'h04, 4'hF, 32'hFFFF_FFFF, 0, 8'h0);
    rd(8'h04, v); chk("R6 id ro", v, 32'h0280_0000);
    cycle(1, 8'h3C, 4'hF, 32'hFFFF_FFFF, 0, 8'h0);
    rd(8'h3C, v); chk("R6 intr ro", v, 32'h0000_0100);
    cycle(1, 8'h44, 4'hF, 32'hFFFF_FFFF, 0, 8'h0);
    rd(8'h44, v); chk("R6 unimpl write", v, 32'h0);
    chk("R5 windows kept", {pm_base, smb_base}, {16'hAB00, 16'hC0C0});
  endtask

  task automatic t_apm;
    cycle(0, 8'h0, 4'h0, 32'h0, 1, 8'hF1);
    chk("R7 sci on", sci_en, 1'b1);
    chk("R7 no smi on F1", smi_pulse, 1'b0);
    cycle(0, 8'h0, 4'h0, 32'h0, 1, 8'h55);
    chk("R8 smi gated off", smi_pulse, 1'b0);
    cycle(1, 8'h58, 4'h8, 32'h0200_0000, 0, 8'h0);
    cycle(0, 8'h0, 4'h0, 32'h0, 1, 8'h55);
    chk("R8 smi pulse", smi_pulse, 1'b1);
    chk("R8 sci unchanged", sci_en, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R8 pulse one cycle", smi_pulse, 1'b0);
    cycle(0, 8'h0, 4'h0, 32'h0, 1, 8'hF0);
    chk("R7 sci off", sci_en, 1'b0);
    chk("R7 no smi on F0", smi_pulse, 1'b0);
  endtask

  task automatic t_same_cycle;
    cycle(1, 8'h58, 4'h8, 32'h0000_0000, 1, 8'h33);
    chk("R9 old bit set", smi_pulse, 1'b1);
    cycle(0, 8'h0, 4'h0, 32'h0, 1, 8'h33);
    chk("R9 new bit clear", smi_pulse, 1'b0);
    cycle(1, 8'h58, 4'h8, 32'h0200_0000, 1, 8'h33);
    chk("R9 old bit clear", smi_pulse, 1'b0);
    cycle(0, 8'h0, 4'h0, 32'h0, 1, 8'h33);
    chk("R9 new bit set", smi_pulse, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_pm_window;
    t_smb_window;
    t_ignore;
    t_apm;
    t_same_cycle;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule